// File: doc/BRIEF.md
# EPROM Pulse-and-Verify Programming Sequencer

This block sits on the programmer side of a byte-wide UV-erasable memory. It writes an image into a range of addresses. A start request latches a first and a last address. The block then fetches each byte to write through a combinational source port and drives the device pins: address, data, an active-low chip select, an active-low read enable and an active-low program strobe. It also drives a supply-select output, where 1 asks the external supplies for programming levels and 0 for normal read levels, and an enable for its own data-bus drivers. All delays are clock-cycle counts derived from a clocks-per-microsecond parameter.

Programming runs in three passes:
- The blind pass gives every address exactly one strobe and reads nothing back.
- The verify pass reads back each byte at programming levels. On a mismatch it adds one more strobe and reads again. This repeats up to a retry limit of ten per byte.
- With the supply back at normal levels, the final pass reads every byte and compares it once more.

The operation ends with a held done flag and either pass or fail. On a fail the block reports the offending address.

Top module: `eprom_prog_seq`

## Requirements
- R1: While no operation runs (after reset, after completion, or after a reset mid-run), `ep_ce_n`, `ep_oe_n` and `ep_pgm_n` are 1, and `prog_supply`, `dbus_oe` and `busy` are 0.
- R2: On `start`, the first program strobe is applied at `first_addr`, and `prog_supply` is 1 during every strobe.
- R3: Every strobe holds `ep_pgm_n` low for exactly `PULSE_US*CLK_PER_US` cycles.
- R4: Before each strobe, `ep_addr`, `ep_dout`, `ep_oe_n` (high), `dbus_oe` (high) and `prog_supply` stay unchanged for at least `SETUP_US*CLK_PER_US` cycles. After each strobe, data stays driven for `HOLD_US*CLK_PER_US` cycles.
- R5: The blind pass gives each address in the range exactly one strobe. A byte that is correct after one strobe gets no further strobe.
- R6: In the verify pass, a byte that needs K strobes (2 ≤ K ≤ 11) gets exactly K strobes in total, and the operation still passes.
- R7: A byte that still mismatches after one blind strobe plus `MAX_RETRY` (10) retry strobes stops the operation at once. The result is `fail`=1 and `fail_addr`=that address, and later addresses get no further strobe.
- R8: `dbus_oe` is 0 whenever `ep_oe_n` is 0. Each read keeps `ep_oe_n` low for at least the cycle equivalent of `VERIFY_NS` before the data is compared.
- R9: The final comparison runs with `prog_supply`=0. A mismatch found only there gives `fail`=1, with `fail_addr` set to that address.
- R10: At completion, `done` rises and stays 1 until the next `start`. `pass` and `fail` are never both 1, and `pass`=1 only when every byte matched in the final comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken when idle) |
| first_addr | input | ADDR_W | First address of the range |
| last_addr | input | ADDR_W | Last address of the range |
| src_addr | output | ADDR_W | Address into the source image |
| src_data | input | DATA_W | Image byte at `src_addr` (combinational) |
| ep_addr | output | ADDR_W | Device address |
| ep_dout | output | DATA_W | Data driven to the device |
| ep_din | input | DATA_W | Data read from the device |
| ep_ce_n | output | 1 | Chip select, active low |
| ep_oe_n | output | 1 | Read enable, active low |
| ep_pgm_n | output | 1 | Program strobe, active low |
| prog_supply | output | 1 | 1 = programming supply levels, 0 = normal |
| dbus_oe | output | 1 | Enable for the programmer's data drivers |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished, held until next start |
| pass | output | 1 | Finished with every byte correct |
| fail | output | 1 | Finished with an error |
| fail_addr | output | ADDR_W | Address that caused the failure |

## Verification
The bench uses a device model in which each address needs its own number of strobes before it reads back correctly. One optional address reads correctly only at programming levels.

The patterns exercise the sequencer in several distinct ways:
- One strobe per byte isolates the blind pass.
- Mixed counts from 2 to 5 exercise retry counting.
- A count of 11 sits exactly on the retry limit, and 12 lies just past it. Together they separate the last permitted retry from the failure path.
- The supply-sensitive byte can only be caught by the final comparison at normal levels.

Per-address strobe counts, strobe widths, setup windows and bus-turnaround behaviour are measured at the pins for every pattern.

// File: rtl/eprom_prog_pkg.sv
package eprom_prog_pkg;

    typedef enum logic [3:0] {
        S_IDLE  = 4'd0,
        S_PSET  = 4'd1,   // setup before strobe
        S_PULSE = 4'd2,   // strobe low
        S_PHOLD = 4'd3,   // data hold after strobe
        S_VTURN = 4'd4,   // bus turnaround before read
        S_VREAD = 4'd5,   // read-back at programming levels
        S_FSUP  = 4'd6,   // supply settle at normal levels
        S_FREAD = 4'd7    // final read-compare
    } seq_state_e;

    function automatic int unsigned ns_to_cycles(int unsigned ns, int unsigned cyc_per_us);
        return (ns * cyc_per_us + 999) / 1000 + 1;
    endfunction

endpackage

// File: rtl/eprom_prog_timer.sv
module eprom_prog_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/eprom_prog_addr.sv
module eprom_prog_addr #(
    parameter int unsigned W = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic         rewind,
    input  logic         inc,
    input  logic [W-1:0] first_in,
    input  logic [W-1:0] last_in,
    output logic [W-1:0] addr,
    output logic         at_last
);
    logic [W-1:0] addr_q, first_q, last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            first_q <= '0;
            last_q  <= '0;
        end else if (capture) begin
            addr_q  <= first_in;
            first_q <= first_in;
            last_q  <= last_in;
        end else if (rewind) begin
            addr_q  <= first_q;
        end else if (inc) begin
            addr_q  <= addr_q + 1'b1;
        end
    end

    assign addr    = addr_q;
    assign at_last = (addr_q == last_q);
endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
    import eprom_prog_pkg::*;
#(
    parameter int unsigned ADDR_W     = 17,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned CLK_PER_US = 4,
    parameter int unsigned PULSE_US   = 100,
    parameter int unsigned SETUP_US   = 2,
    parameter int unsigned HOLD_US    = 2,
    parameter int unsigned VERIFY_NS  = 150,
    parameter int unsigned MAX_RETRY  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] first_addr,
    input  logic [ADDR_W-1:0] last_addr,
    output logic [ADDR_W-1:0] src_addr,
    input  logic [DATA_W-1:0] src_data,
    output logic [ADDR_W-1:0] ep_addr,
    output logic [DATA_W-1:0] ep_dout,
    input  logic [DATA_W-1:0] ep_din,
    output logic              ep_ce_n,
    output logic              ep_oe_n,
    output logic              ep_pgm_n,
    output logic              prog_supply,
    output logic              dbus_oe,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr
);
    localparam int unsigned PULSE_CYC  = PULSE_US * CLK_PER_US;
    localparam int unsigned SETUP_CYC  = SETUP_US * CLK_PER_US;
    localparam int unsigned HOLD_CYC   = HOLD_US * CLK_PER_US;
    localparam int unsigned VERIFY_CYC = ns_to_cycles(VERIFY_NS, CLK_PER_US);
    localparam int unsigned MAX_CYC    = PULSE_CYC;
    localparam int unsigned TMR_W      = $clog2(MAX_CYC + 1);
    localparam int unsigned RETRY_W    = $clog2(MAX_RETRY + 1);

    typedef struct packed {
        seq_state_e          state;
        logic                verify_ph;
        logic [RETRY_W-1:0]  retry;
        logic                done;
        logic                pass;
        logic                fail;
        logic [ADDR_W-1:0]   fail_addr;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic              tmr_load, tmr_zero;
    logic [TMR_W-1:0]  tmr_val;
    logic              a_capture, a_rewind, a_inc, at_last;
    logic [ADDR_W-1:0] addr;
    logic              match;

    eprom_prog_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    eprom_prog_addr #(.W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (a_capture),
        .rewind   (a_rewind),
        .inc      (a_inc),
        .first_in (first_addr),
        .last_in  (last_addr),
        .addr     (addr),
        .at_last  (at_last)
    );

    assign match = (ep_din == src_data);

    always_comb begin
        r_d       = r_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        a_capture = 1'b0;
        a_rewind  = 1'b0;
        a_inc     = 1'b0;
        unique case (r_q.state)
            S_IDLE: begin
                if (start) begin
                    a_capture   = 1'b1;
                    r_d.state   = S_PSET;
                    r_d.verify_ph = 1'b0;
                    r_d.retry   = '0;
                    r_d.done    = 1'b0;
                    r_d.pass    = 1'b0;
                    r_d.fail    = 1'b0;
                    r_d.fail_addr = '0;
                    tmr_load    = 1'b1;
                    tmr_val     = TMR_W'(SETUP_CYC - 1);
                end
            end
            S_PSET: begin
                if (tmr_zero) begin
                    r_d.state = S_PULSE;
                    tmr_load  = 1'b1;
                    tmr_val   = TMR_W'(PULSE_CYC - 1);
                end
            end
            S_PULSE: begin
                if (tmr_zero) begin
                    r_d.state = S_PHOLD;
                    tmr_load  = 1'b1;
                    tmr_val   = TMR_W'(HOLD_CYC - 1);
                end
            end
            S_PHOLD: begin
                if (tmr_zero) begin
                    if (r_q.verify_ph) begin
                        r_d.state = S_VTURN;
                    end else if (at_last) begin
                        r_d.verify_ph = 1'b1;
                        a_rewind  = 1'b1;
                        r_d.state = S_VTURN;
                    end else begin
                        a_inc     = 1'b1;
                        r_d.state = S_PSET;
                        tmr_load  = 1'b1;
                        tmr_val   = TMR_W'(SETUP_CYC - 1);
                    end
                end
            end
            S_VTURN: begin
                r_d.state = S_VREAD;
                tmr_load  = 1'b1;
                tmr_val   = TMR_W'(VERIFY_CYC - 1);
            end
            S_VREAD: begin
                if (tmr_zero) begin
                    if (match) begin
                        r_d.retry = '0;
                        if (at_last) begin
                            a_rewind  = 1'b1;
                            r_d.state = S_FSUP;
                            tmr_load  = 1'b1;
                            tmr_val   = TMR_W'(SETUP_CYC - 1);
                        end else begin
                            a_inc     = 1'b1;
                            r_d.state = S_VTURN;
                        end
                    end else if (r_q.retry == RETRY_W'(MAX_RETRY)) begin
                        r_d.state     = S_IDLE;
                        r_d.done      = 1'b1;
                        r_d.fail      = 1'b1;
                        r_d.fail_addr = addr;
                    end else begin
                        r_d.retry = r_q.retry + 1'b1;
                        r_d.state = S_PSET;
                        tmr_load  = 1'b1;
                        tmr_val   = TMR_W'(SETUP_CYC - 1);
                    end
                end
            end
            S_FSUP: begin
                if (tmr_zero) begin
                    r_d.state = S_FREAD;
                    tmr_load  = 1'b1;
                    tmr_val   = TMR_W'(VERIFY_CYC - 1);
                end
            end
            S_FREAD: begin
                if (tmr_zero) begin
                    if (!match) begin
                        r_d.state     = S_IDLE;
                        r_d.done      = 1'b1;
                        r_d.fail      = 1'b1;
                        r_d.fail_addr = addr;
                    end else if (at_last) begin
                        r_d.state = S_IDLE;
                        r_d.done  = 1'b1;
                        r_d.pass  = 1'b1;
                    end else begin
                        a_inc    = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = TMR_W'(VERIFY_CYC - 1);
                    end
                end
            end
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: S_IDLE, verify_ph: 1'b0, retry: '0, done: 1'b0,
                     pass: 1'b0, fail: 1'b0, fail_addr: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign src_addr    = addr;
    assign ep_addr     = addr;
    assign ep_dout     = src_data;
    assign busy        = (r_q.state != S_IDLE);
    assign ep_ce_n     = (r_q.state == S_IDLE);
    assign ep_pgm_n    = (r_q.state != S_PULSE);
    assign ep_oe_n     = !((r_q.state == S_VREAD) || (r_q.state == S_FREAD));
    assign dbus_oe     = (r_q.state == S_PSET) || (r_q.state == S_PULSE) ||
                         (r_q.state == S_PHOLD);
    assign prog_supply = dbus_oe || (r_q.state == S_VTURN) || (r_q.state == S_VREAD);
    assign done        = r_q.done;
    assign pass        = r_q.pass;
    assign fail        = r_q.fail;
    assign fail_addr   = r_q.fail_addr;
endmodule

// File: rtl/eprom_prog_chk.sv
module eprom_prog_chk #(
    parameter int unsigned ADDR_W     = 17,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned PULSE_CYC  = 400,
    parameter int unsigned SETUP_CYC  = 8,
    parameter int unsigned VERIFY_CYC = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              pass,
    input logic              fail,
    input logic              ep_ce_n,
    input logic              ep_oe_n,
    input logic              ep_pgm_n,
    input logic              prog_supply,
    input logic              dbus_oe,
    input logic [ADDR_W-1:0] ep_addr,
    input logic [DATA_W-1:0] ep_dout
);
    localparam int unsigned SIG_W = ADDR_W + DATA_W + 3;

    logic [31:0]      low_cnt_q, oe_cnt_q, stable_cnt_q;
    logic [SIG_W-1:0] sig, sig_q;

    assign sig = {ep_addr, ep_dout, ep_oe_n, dbus_oe, prog_supply};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt_q    <= '0;
            oe_cnt_q     <= '0;
            stable_cnt_q <= '0;
            sig_q        <= '0;
        end else begin
            low_cnt_q <= ep_pgm_n ? '0 : low_cnt_q + 1'b1;
            oe_cnt_q  <= ep_oe_n  ? '0 : oe_cnt_q + 1'b1;
            sig_q     <= sig;
            if (sig != sig_q)               stable_cnt_q <= '0;
            else if (stable_cnt_q != '1)    stable_cnt_q <= stable_cnt_q + 1'b1;
        end
    end

    AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ep_ce_n && ep_oe_n && ep_pgm_n && !prog_supply && !dbus_oe)); // R1
    AST_STROBE_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        !ep_pgm_n |-> (prog_supply && !ep_ce_n)); // R2
    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ep_pgm_n) |-> (low_cnt_q == PULSE_CYC)); // R3
    AST_SETUP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ep_pgm_n) |-> (stable_cnt_q >= SETUP_CYC - 1)); // R4
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ep_pgm_n) |-> (dbus_oe && $stable(ep_dout) && $stable(ep_addr))); // R4
    AST_BUS_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        !ep_oe_n |-> !dbus_oe); // R8
    AST_READ_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ep_oe_n) |-> (oe_cnt_q >= VERIFY_CYC)); // R8
    AST_FINAL_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !prog_supply); // R9
    AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass && fail)); // R10
    AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !busy && $past(!busy)) |-> $stable(done) && $stable(pass)); // R10
endmodule

bind eprom_prog_seq eprom_prog_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .PULSE_CYC  (PULSE_CYC),
    .SETUP_CYC  (SETUP_CYC),
    .VERIFY_CYC (VERIFY_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .pass        (pass),
    .fail        (fail),
    .ep_ce_n     (ep_ce_n),
    .ep_oe_n     (ep_oe_n),
    .ep_pgm_n    (ep_pgm_n),
    .prog_supply (prog_supply),
    .dbus_oe     (dbus_oe),
    .ep_addr     (ep_addr),
    .ep_dout     (ep_dout)
);

// File: tb/eprom_prog_seq_tb.sv
module eprom_prog_seq_tb;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int CPU = 2;
    localparam int EXP_PULSE = 100 * CPU;
    localparam int EXP_SETUP = 2 * CPU;
    localparam int EXP_VWAIT = 1;

    typedef struct packed {
        logic [7:0]       first;
        logic [7:0]       last;
        logic [3:0][3:0]  k;       // k[i]: strobes needed at first+i
        logic             weak_en;
        logic [1:0]       weak_idx;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{8'd10, 8'd13, {4'd1, 4'd1, 4'd1, 4'd1},  1'b0, 2'd0},
        '{8'd20, 8'd23, {4'd5, 4'd1, 4'd3, 4'd1},  1'b0, 2'd0},
        '{8'd30, 8'd31, {4'd0, 4'd0, 4'd0, 4'd11}, 1'b0, 2'd0},
        '{8'd40, 8'd43, {4'd1, 4'd1, 4'd12, 4'd1}, 1'b0, 2'd0},
        '{8'd50, 8'd52, {4'd0, 4'd1, 4'd1, 4'd2},  1'b1, 2'd2},
        '{8'd60, 8'd60, {4'd0, 4'd0, 4'd0, 4'd1},  1'b0, 2'd0}
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [AW-1:0] first_addr = '0, last_addr = '0;
    logic [AW-1:0] src_addr, ep_addr, fail_addr;
    logic [DW-1:0] src_data, ep_dout, ep_din;
    logic ep_ce_n, ep_oe_n, ep_pgm_n, prog_supply, dbus_oe, busy, done, pass, fail;

    int checks = 0, errors = 0, cyc = 0;
    bit wd_hit = 1'b0;
    int kmem  [256];
    int pcnt  [256];
    int weak_addr = -1;
    int first_pulse_addr = -1;
    int bad_width = 0, bad_setup = 0, bad_clash = 0, bad_rd = 0;
    int low_run = 0, oe_run = 0, stable_run = 0;
    logic prev_pgm = 1'b1, prev_oe = 1'b1;
    logic [AW+DW+2:0] prev_sig = '0;

    always #5 clk = ~clk;

    eprom_prog_seq #(.ADDR_W(AW), .DATA_W(DW), .CLK_PER_US(CPU)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .first_addr(first_addr),
        .last_addr(last_addr), .src_addr(src_addr), .src_data(src_data),
        .ep_addr(ep_addr), .ep_dout(ep_dout), .ep_din(ep_din),
        .ep_ce_n(ep_ce_n), .ep_oe_n(ep_oe_n), .ep_pgm_n(ep_pgm_n),
        .prog_supply(prog_supply), .dbus_oe(dbus_oe), .busy(busy),
        .done(done), .pass(pass), .fail(fail), .fail_addr(fail_addr)
    );

    function automatic logic [7:0] img(input logic [7:0] a);
        return a ^ 8'h5A;
    endfunction

    // device model: a cell reads its image once it has seen enough strobes
    always_comb begin
        src_data = img(src_addr);
        if (ep_ce_n || ep_oe_n)                    ep_din = 8'hFF;
        else if (pcnt[ep_addr] < kmem[ep_addr])    ep_din = 8'hFF;
        else if (int'(ep_addr) == weak_addr && !prog_supply) ep_din = ~img(ep_addr);
        else                                       ep_din = img(ep_addr);
    end

    // pin monitors, sampled away from the active edge
    always @(negedge clk) begin
        logic [AW+DW+2:0] sig;
        cyc++;
        sig = {ep_addr, ep_dout, ep_oe_n, dbus_oe, prog_supply};
        if (!ep_pgm_n && prev_pgm) begin
            pcnt[ep_addr]++;
            if (first_pulse_addr < 0) first_pulse_addr = int'(ep_addr);
            if (stable_run < EXP_SETUP || !prog_supply || !dbus_oe || !ep_oe_n) bad_setup++;
        end
        if (ep_pgm_n && !prev_pgm && low_run != EXP_PULSE) bad_width++;
        if (ep_oe_n && !prev_oe && oe_run < EXP_VWAIT) bad_rd++;
        if (!ep_oe_n && dbus_oe) bad_clash++;
        low_run    = ep_pgm_n ? 0 : low_run + 1;
        oe_run     = ep_oe_n ? 0 : oe_run + 1;
        stable_run = (sig == prev_sig) ? stable_run + 1 : 1;
        prev_sig = sig;
        prev_pgm = ep_pgm_n;
        prev_oe  = ep_oe_n;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_idle(input string req);
        check(req, "ce_n", int'(ep_ce_n), 1);
        check(req, "oe_n", int'(ep_oe_n), 1);
        check(req, "pgm_n", int'(ep_pgm_n), 1);
        check(req, "prog_supply", int'(prog_supply), 0);
        check(req, "dbus_oe", int'(dbus_oe), 0);
        check(req, "busy", int'(busy), 0);
    endtask

    task automatic wait_done();
        while (!done && !wd_hit) begin
            @(negedge clk);
            if (cyc > 190000) wd_hit = 1'b1;
        end
    endtask

    task automatic run_vec(input vec_t v);
        int n, fidx, exp_fail_addr;
        bit exp_pass;
        n = int'(v.last) - int'(v.first) + 1;
        for (int a = 0; a < 256; a++) begin kmem[a] = 0; pcnt[a] = 0; end
        for (int i = 0; i < n; i++) kmem[int'(v.first) + i] = int'(v.k[i]);
        weak_addr = v.weak_en ? int'(v.first) + int'(v.weak_idx) : -1;
        bad_width = 0; bad_setup = 0; bad_clash = 0; bad_rd = 0;
        first_pulse_addr = -1;
        // expected result from the requirements
        fidx = -1;
        for (int i = 0; i < n; i++) if (fidx < 0 && int'(v.k[i]) > 11) fidx = i;
        exp_pass = (fidx < 0) && !v.weak_en;
        exp_fail_addr = (fidx >= 0) ? int'(v.first) + fidx
                      : (v.weak_en ? weak_addr : 0);
        @(negedge clk);
        first_addr = v.first; last_addr = v.last; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R10", "done cleared by start", int'(done), 0);
        wait_done();
        check("R10", "done", int'(done), 1);
        check("R10", "pass", int'(pass), int'(exp_pass));
        check("R10", "fail", int'(fail), int'(!exp_pass));
        if (!exp_pass) check(fidx >= 0 ? "R7" : "R9", "fail_addr", int'(fail_addr), exp_fail_addr);
        check("R2", "first strobe address", first_pulse_addr, int'(v.first));
        for (int i = 0; i < n; i++) begin
            int e;
            if (fidx >= 0 && i > fidx)      e = 1;
            else if (fidx >= 0 && i == fidx) e = 11;
            else                             e = (int'(v.k[i]) < 1) ? 1 : int'(v.k[i]);
            check(int'(v.k[i]) <= 1 || (fidx >= 0 && i > fidx) ? "R5" :
                  (i == fidx ? "R7" : "R6"), $sformatf("strobes at %0d", int'(v.first) + i),
                  pcnt[int'(v.first) + i], e);
        end
        check("R3", "strobe width errors", bad_width, 0);
        check("R4", "setup window errors", bad_setup, 0);
        check("R8", "bus clash", bad_clash, 0);
        check("R8", "read wait errors", bad_rd, 0);
        repeat (5) @(negedge clk);
        check("R10", "done held", int'(done), 1);
        check("R1", "idle after done (ce_n)", int'(ep_ce_n), 1);
        check("R9", "supply normal at end", int'(prog_supply), 0);
    endtask

    initial begin
        for (int a = 0; a < 256; a++) begin kmem[a] = 0; pcnt[a] = 0; end
        repeat (3) @(negedge clk);
        check_idle("R1");
        check("R10", "done at reset", int'(done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_idle("R1");

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // directed: reset in the middle of a strobe returns pins to idle
        for (int a = 0; a < 256; a++) begin kmem[a] = 1; pcnt[a] = 0; end
        weak_addr = -1;
        first_addr = 8'd70; last_addr = 8'd72; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (EXP_SETUP + 20) @(negedge clk);
        check("R2", "strobe under way", int'(ep_pgm_n), 0);
        rst_n = 1'b0;
        @(negedge clk);
        check_idle("R1");
        check("R10", "done after mid-run reset", int'(done), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_idle("R1");

        if (wd_hit) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule